// File: doc/BRIEF.md
# Shared-Line Readout Controller for a Delta-Sigma Converter

This block is the digital controller that sits between a delta-sigma converter core and a host that talks to it over only two wires: a host-driven serial clock and one output line that carries both the "result ready" flag and the serial result bits. The line sits high while nothing new is available. It drops low when a conversion result is latched, and from then on each rising serial clock edge puts the next result bit on the line, most significant bit first, two's complement.

There is no command port. The host controls the block only through how many rising edges it gives and how long it keeps the clock high. The edge after the last data bit returns the line high. One further pulse requests a self-calibration. A high phase longer than a programmable number of system clocks puts the block to sleep. Lowering the clock wakes it, and a calibration runs first if the sleep began on that extra command pulse. Conversion and calibration timing are outside the block: the converter core signals finished results and finished calibrations with one-cycle strobes, and the block requests calibrations with a one-cycle pulse. A calibration is also requested automatically after reset.

Top module: `sline_readout`

## Requirements
- R1: The output line is high while no unread result is pending, and is low in the cycle after a conversion strobe is accepted (accepted only when awake and not calibrating).
- R2: With a result pending, rising serial clock edges 1 to DATA_W put result bits DATA_W-1 down to 0 on the line, one per edge, so edge k shows bit DATA_W-k.
- R3: After the last data bit the line holds that bit until the next rising edge (edge DATA_W+1), which drives the line high.
- R4: The falling edge of pulse DATA_W+2 produces exactly one cycle of cal_req; the line stays high, and the next result strobe after the calibration-done strobe pulls it low again.
- R5: A conversion strobe that arrives before or during a readout replaces the pending result and restarts the bit sequence at the MSB of the new result.
- R6: Once a result has been flagged, a serial clock high phase of HOLD_CYC system clocks or more puts the block to sleep: sleep_en goes to 1 and the line goes high, whether or not the word was read.
- R7: A falling serial clock edge in sleep clears sleep_en without a calibration request (unless R8 applies), and the next result strobe pulls the line low.
- R8: If the sleep began while the high phase was pulse DATA_W+2, waking produces one cal_req pulse before conversions resume.
- R9: After reset the line is high, sleep_en is 0, and exactly one cal_req pulse is issued; result strobes are ignored until the calibration-done strobe.
- R10: A high phase shorter than HOLD_CYC system clocks acts as an ordinary clock pulse and never sets sleep_en.
- R11: Result strobes during sleep are ignored: the line stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk_in | input | 1 | Host serial clock, asynchronous to clk |
| conv_valid | input | 1 | One-cycle strobe: a conversion result is ready |
| conv_word | input | DATA_W | Conversion result, two's complement, valid with conv_valid |
| cal_valid | input | 1 | One-cycle strobe: calibration finished |
| ready_data | output | 1 | Combined ready flag and serial data line |
| cal_req | output | 1 | One-cycle calibration request pulse |
| sleep_en | output | 1 | High while the block is asleep |

## Verification
The assertions assume that the serial clock changes slowly against the system clock, so that each high and each low phase lasts at least a few system clocks after synchronisation and no edge is lost. They also assume that the core raises its calibration-done strobe only after a request and never raises both strobes in one cycle. The bench drives every serial clock phase for at least five system clocks, changes inputs only on the falling system clock edge, and sends calibration-done only after it has counted a request pulse. Normal phases stay well under the sleep threshold, and sleep holds stay well over it.

// File: rtl/sline_pkg.sv
package sline_pkg;

    typedef enum logic [1:0] {
        ST_CAL   = 2'd0,
        ST_RUN   = 2'd1,
        ST_SLEEP = 2'd2
    } sline_state_t;

    typedef struct packed {
        logic rise;
        logic fall;
        logic hold;
        logic level;
    } sclk_evt_t;

    function automatic int edge_cnt_w(input int data_w);
        return $clog2(data_w + 3);
    endfunction

    function automatic int hold_cnt_w(input int hold_cyc);
        return $clog2(hold_cyc + 1);
    endfunction

endpackage

// File: rtl/sline_sclk_front.sv
module sline_sclk_front
    import sline_pkg::*;
#(
    parameter int HOLD_CYC = 16
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      sclk_in,
    output sclk_evt_t evt
);
    localparam int HW = hold_cnt_w(HOLD_CYC);
    localparam logic [HW-1:0] HOLD_LAST = HW'(HOLD_CYC - 1);
    localparam logic [HW-1:0] HOLD_MAX  = HW'(HOLD_CYC);

    logic          sync_a, sync_b, sync_prev;
    logic [HW-1:0] hi_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_a    <= 1'b0;
            sync_b    <= 1'b0;
            sync_prev <= 1'b0;
            hi_cnt    <= '0;
        end else begin
            sync_a    <= sclk_in;
            sync_b    <= sync_a;
            sync_prev <= sync_b;
            if (!sync_b)
                hi_cnt <= '0;
            else if (hi_cnt != HOLD_MAX)
                hi_cnt <= hi_cnt + 1'b1;
        end
    end

    always_comb begin
        evt.rise  = sync_b & ~sync_prev;
        evt.fall  = ~sync_b & sync_prev;
        evt.hold  = sync_b & (hi_cnt == HOLD_LAST);
        evt.level = sync_b;
    end

    // R10: a hold indication needs the line to have been high the cycle before
    assert_hold_after_high_R10: assert property (@(posedge clk) disable iff (rst)
        evt.hold |-> $past(sync_b));

endmodule

// File: rtl/sline_word_shift.sv
module sline_word_shift
    import sline_pkg::*;
#(
    parameter int DATA_W = 24
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [DATA_W-1:0] load_word,
    input  logic              adv,
    input  logic              force_high,
    output logic              line,
    output logic              cmd_armed
);
    localparam int CW = edge_cnt_w(DATA_W);
    localparam logic [CW-1:0] LAST_BIT  = CW'(DATA_W);
    localparam logic [CW-1:0] CMD_EDGE  = CW'(DATA_W + 2);

    logic [DATA_W-1:0] word_q;
    logic [CW-1:0]     edge_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            word_q   <= '0;
            edge_cnt <= '0;
            line     <= 1'b1;
        end else if (force_high) begin
            edge_cnt <= '0;
            line     <= 1'b1;
        end else if (load) begin
            word_q   <= load_word;
            edge_cnt <= '0;
            line     <= 1'b0;
        end else if (adv) begin
            if (edge_cnt < LAST_BIT) begin
                line   <= word_q[DATA_W-1];
                word_q <= word_q << 1;
            end else begin
                line <= 1'b1;
            end
            if (edge_cnt != CMD_EDGE)
                edge_cnt <= edge_cnt + 1'b1;
        end
    end

    assign cmd_armed = (edge_cnt == CMD_EDGE);

    // R3: with no load, edge or forced exit the line keeps its value
    assert_line_holds_R3: assert property (@(posedge clk) disable iff (rst)
        (!load && !adv && !force_high) |=> $stable(line));

    // R3: the edge after the last data bit returns the line high
    assert_extra_edge_high_R3: assert property (@(posedge clk) disable iff (rst)
        (adv && !load && !force_high && edge_cnt == LAST_BIT) |=> line);

endmodule

// File: rtl/sline_readout.sv
module sline_readout
    import sline_pkg::*;
#(
    parameter int DATA_W   = 24,
    parameter int HOLD_CYC = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sclk_in,
    input  logic              conv_valid,
    input  logic [DATA_W-1:0] conv_word,
    input  logic              cal_valid,
    output logic              ready_data,
    output logic              cal_req,
    output logic              sleep_en
);
    sline_state_t state;
    sclk_evt_t    evt;
    logic         have_data;
    logic         wake_cal;
    logic         req_pend;
    logic         cmd_armed;

    logic do_sleep, do_load, do_cal, do_adv, do_force;

    sline_sclk_front #(.HOLD_CYC(HOLD_CYC)) u_front (
        .clk     (clk),
        .rst     (rst),
        .sclk_in (sclk_in),
        .evt     (evt)
    );

    always_comb begin
        do_sleep = (state == ST_RUN) && have_data && evt.hold;
        do_load  = (state == ST_RUN) && !do_sleep && conv_valid;
        do_cal   = (state == ST_RUN) && !do_sleep && !conv_valid &&
                   have_data && evt.fall && cmd_armed;
        do_adv   = (state == ST_RUN) && have_data && !do_sleep &&
                   !conv_valid && evt.rise;
        do_force = do_sleep || do_cal;
    end

    sline_word_shift #(.DATA_W(DATA_W)) u_shift (
        .clk        (clk),
        .rst        (rst),
        .load       (do_load),
        .load_word  (conv_word),
        .adv        (do_adv),
        .force_high (do_force),
        .line       (ready_data),
        .cmd_armed  (cmd_armed)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_CAL;
            have_data <= 1'b0;
            wake_cal  <= 1'b0;
            req_pend  <= 1'b1;
            cal_req   <= 1'b0;
        end else begin
            cal_req <= 1'b0;
            if (req_pend) begin
                cal_req  <= 1'b1;
                req_pend <= 1'b0;
            end
            unique case (state)
                ST_CAL: begin
                    if (cal_valid && !req_pend) begin
                        state     <= ST_RUN;
                        have_data <= 1'b0;
                    end
                end
                ST_RUN: begin
                    if (do_sleep) begin
                        state     <= ST_SLEEP;
                        wake_cal  <= cmd_armed;
                        have_data <= 1'b0;
                    end else if (do_load) begin
                        have_data <= 1'b1;
                    end else if (do_cal) begin
                        state     <= ST_CAL;
                        req_pend  <= 1'b1;
                        have_data <= 1'b0;
                    end
                end
                ST_SLEEP: begin
                    if (evt.fall) begin
                        if (wake_cal) begin
                            state    <= ST_CAL;
                            req_pend <= 1'b1;
                        end else begin
                            state <= ST_RUN;
                        end
                        wake_cal <= 1'b0;
                    end
                end
                default: state <= ST_CAL;
            endcase
        end
    end

    assign sleep_en = (state == ST_SLEEP);

    // R1: an accepted result pulls the line low on the next cycle
    assert_load_low_R1: assert property (@(posedge clk) disable iff (rst)
        do_load |=> !ready_data);

    // R6: the line is high for the whole time the block sleeps
    assert_sleep_line_high_R6: assert property (@(posedge clk) disable iff (rst)
        sleep_en |-> ready_data);

    // R4: a calibration request lasts exactly one cycle
    assert_req_single_R4: assert property (@(posedge clk) disable iff (rst)
        cal_req |=> !cal_req);

    // R9: while calibrating no result is flagged
    assert_cal_line_high_R9: assert property (@(posedge clk) disable iff (rst)
        (state == ST_CAL) |-> ready_data);

    // R11: a strobe during sleep leaves the line high
    assert_sleep_ignores_R11: assert property (@(posedge clk) disable iff (rst)
        (sleep_en && !evt.fall) |=> ready_data);

endmodule

// File: tb/sline_readout_tb.sv
module sline_readout_tb;
    localparam int DATA_W   = 24;
    localparam int HOLD_CYC = 16;
    localparam int PH       = 5;

    logic              clk = 1'b0;
    logic              rst;
    logic              sclk_in;
    logic              conv_valid;
    logic [DATA_W-1:0] conv_word;
    logic              cal_valid;
    logic              ready_data;
    logic              cal_req;
    logic              sleep_en;

    int checks = 0;
    int errors = 0;
    int req_count = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    sline_readout #(.DATA_W(DATA_W), .HOLD_CYC(HOLD_CYC)) u_dut (
        .clk        (clk),
        .rst        (rst),
        .sclk_in    (sclk_in),
        .conv_valid (conv_valid),
        .conv_word  (conv_word),
        .cal_valid  (cal_valid),
        .ready_data (ready_data),
        .cal_req    (cal_req),
        .sleep_en   (sleep_en)
    );

    always @(negedge clk) if (!rst && cal_req) req_count++;

    task automatic check(input logic act, input logic exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
        end
    endtask

    task automatic check_int(input int act, input int exp, input string tag);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_sclk(input int hi);
        sclk_in = 1'b1;
        wait_n(hi);
        sclk_in = 1'b0;
        wait_n(PH);
    endtask

    task automatic send_conv(input logic [DATA_W-1:0] w);
        conv_word  = w;
        conv_valid = 1'b1;
        wait_n(1);
        conv_valid = 1'b0;
        wait_n(3);
    endtask

    task automatic send_cal_done();
        cal_valid = 1'b1;
        wait_n(1);
        cal_valid = 1'b0;
        wait_n(3);
    endtask

    task automatic read_word(input logic [DATA_W-1:0] w, input string tag);
        int bad = 0;
        for (int b = DATA_W - 1; b >= 0; b--) begin
            pulse_sclk(PH);
            checks++;
            if (ready_data !== w[b]) begin
                bad++;
                errors++;
                $display("FAIL %s bit%0d actual=%0b expected=%0b", tag, b, ready_data, w[b]);
            end
        end
    endtask

    function automatic logic [DATA_W-1:0] pattern(input int i);
        logic [31:0] v;
        if (i == 0) return 24'h800000;
        if (i == 1) return 24'h7FFFFF;
        v = i * 32'h009E3779 + i * i * 32'h00012345;
        if (i[0]) v = ~v;
        return v[DATA_W-1:0];
    endfunction

    initial begin
        wait_n(100000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [DATA_W-1:0] wa, wb;
        int rc;
        rst = 1'b1; sclk_in = 1'b0; conv_valid = 1'b0; conv_word = '0; cal_valid = 1'b0;
        wait_n(4);
        rst = 1'b0;
        wait_n(1);
        check(ready_data, 1'b1, "R9 line high after reset");
        check(sleep_en, 1'b0, "R9 awake after reset");
        wait_n(4);
        check_int(req_count, 1, "R9 one request after reset");
        send_conv(24'h123456);
        check(ready_data, 1'b1, "R9 strobe ignored before calibration done");
        send_cal_done();
        check(ready_data, 1'b1, "R1 idle high with nothing pending");

        // R1 R2 R3 R10: sweep over result patterns
        for (int i = 0; i < 16; i++) begin
            wa = pattern(i);
            send_conv(wa);
            check(ready_data, 1'b0, "R1 ready low after result");
            read_word(wa, "R2 data bit");
            wait_n(12);
            check(ready_data, wa[0], "R3 line keeps last bit");
            check(sleep_en, 1'b0, "R10 short phases never sleep");
            pulse_sclk(PH);
            check(ready_data, 1'b1, "R3 extra edge returns high");
        end

        // R10: high phase just under the threshold
        send_conv(24'hC00001);
        pulse_sclk(HOLD_CYC - 4);
        check(sleep_en, 1'b0, "R10 sub-threshold phase not sleep");
        check(ready_data, 1'b1, "R10 sub-threshold phase gives MSB");

        // R5: overwrite in mid-read
        wa = 24'h0F0F0F; wb = 24'hB3C5A9;
        send_conv(wa);
        for (int k = 0; k < 5; k++) pulse_sclk(PH);
        send_conv(wb);
        check(ready_data, 1'b0, "R5 new result flagged");
        read_word(wb, "R5 new word from MSB");
        pulse_sclk(PH);

        // R4: extra command pulse starts calibration
        wa = 24'h5A5A5A;
        send_conv(wa);
        read_word(wa, "R4 word before command");
        rc = req_count;
        pulse_sclk(PH);
        pulse_sclk(PH);
        wait_n(4);
        check_int(req_count, rc + 1, "R4 one request after command pulse");
        check(ready_data, 1'b1, "R4 line high during calibration");
        send_conv(24'h111111);
        check(ready_data, 1'b1, "R4 strobe ignored while calibrating");
        send_cal_done();
        wa = 24'h9ABCDE;
        send_conv(wa);
        check(ready_data, 1'b0, "R4 ready after calibration");
        read_word(wa, "R4 word after calibration");
        pulse_sclk(PH);

        // R6 R7 R11: partial read then sleep
        wa = 24'hE01234;
        send_conv(wa);
        for (int k = 0; k < 3; k++) pulse_sclk(PH);
        rc = req_count;
        sclk_in = 1'b1;
        wait_n(HOLD_CYC + 8);
        check(sleep_en, 1'b1, "R6 long high enters sleep");
        check(ready_data, 1'b1, "R6 line high in sleep");
        send_conv(24'h000000);
        check(ready_data, 1'b1, "R11 strobe ignored in sleep");
        sclk_in = 1'b0;
        wait_n(PH);
        check(sleep_en, 1'b0, "R7 falling edge wakes");
        check_int(req_count, rc, "R7 no request on plain wake");
        wa = 24'h3C3C3C;
        send_conv(wa);
        check(ready_data, 1'b0, "R7 ready after wake");
        read_word(wa, "R7 word after wake");
        pulse_sclk(PH);

        // R8: sleep on the command pulse, calibrate on wake
        wa = 24'h876543;
        send_conv(wa);
        read_word(wa, "R8 word before sleep");
        pulse_sclk(PH);
        rc = req_count;
        sclk_in = 1'b1;
        wait_n(HOLD_CYC + 8);
        check(sleep_en, 1'b1, "R8 sleep on command pulse");
        check_int(req_count, rc, "R8 no request while asleep");
        sclk_in = 1'b0;
        wait_n(PH);
        check_int(req_count, rc + 1, "R8 request on wake");
        check(sleep_en, 1'b0, "R8 awake");
        send_cal_done();
        wa = 24'h400002;
        send_conv(wa);
        check(ready_data, 1'b0, "R8 ready after wake calibration");
        read_word(wa, "R8 word after wake calibration");

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule